// File: doc/BRIEF.md
# Synchronized Event-Driven FSM Network

This block is a small network of finite state machines, called processes, that listen to a common set of broadcast event wires and change state in lockstep. Each process listens only to its own subset of the wires, called its sort. It packs the bits of its sort into a minterm index, with the lowest-numbered wire of the sort as the least significant bit. When none of its wires is high, the index is 0, the null event. A fixed transition table, given as a parameter, tells each process which minterms lead from each current state to each next state.

Each process ANDs every guard with its current one-hot state bit. It merges the results per target state into next-state selects, and it raises a request when any select is active. A single synchronization term is the AND of all requests. When that term is high, every process takes its selected transition on the next rising clock edge. When any process refuses the present event combination, the whole network holds for that cycle.

The default parameters build two processes on four event wires a, b, c, d (wire bits 0 to 3). Process P has sort {a, b, c} and four states. Process Q has sort {c, d} and three states. The two processes share wire c.

Top module: `evt_fsm_net`

## Requirements
- R1: A synchronous active-high reset loads every process with its initial one-hot state on the next rising edge: P in S1 (`state_out[3:0]` = 0001) and Q in U0 (`state_out[7:4]` = 0001). Process p owns bits `state_out[p*N_ST +: N_ST]`, and state k is bit k of that slice.
- R2: After reset, each process slice of `state_out` always has exactly one bit set.
- R3: A process forms its minterm only from the wires in its sort, with the lowest-numbered wire as bit 0. Wires outside its sort have no effect on it. P's minterm is {c,b,a}, and Q's minterm is {d,c}.
- R4: When `sync_out` is high, each process moves on the next rising edge to the state its table selects. P's table: S1: m0 stays, m5 goes to S2, m2 goes to S3. S2: m0 and m2 stay, m1 goes to S3. S3: m0 stays, m3 goes to S4. S4: m0 and m4 stay, m1 goes to S2. Q's table: U0: m0 stays, m1 goes to U1, m2 goes to U2. U1: m0 stays, m2 goes to U0, m3 goes to U0 and to U2. U2: m0 stays, m1 goes to U0.
- R5: `req_out[p]` is high exactly when the present minterm of process p guards some transition out of its current state. `sync_out` is high exactly when every `req_out` bit is high.
- R6: When any process refuses the present event combination, `sync_out` is low and no process changes state on the next edge, even a process that would accept the event.
- R7: When several guards out of the current state match, the lowest-numbered next state is taken. For example, Q in U1 on minterm 3 goes to U0.
- R8: `sync_out` and `req_out` follow the event inputs in the same cycle. `state_out` is registered and changes only at the rising edge after the events are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | N_EVT | Broadcast event wires, bit 0 = a |
| state_out | output | N_PROC*N_ST | Registered one-hot state of every process |
| req_out | output | N_PROC | Per-process acceptance request |
| sync_out | output | 1 | Global synchronization term |

## Verification
A corrupted state register in one process shows up in the same cycle as a wrong `req_out` bit and a wrong `sync_out`, because acceptance is judged from the current state. One edge later the error spreads, since the other processes then freeze or advance when they should not. A broken minterm decode, wire routing or priority select appears at `state_out` on the first edge after the offending event pattern. For that reason the directed table hits every arc and the shared wire, and a long random walk compares every cycle against an independent model of the two tables.

// File: rtl/evt_net_pkg.sv
package evt_net_pkg;

  localparam int DEF_N_PROC = 2;
  localparam int DEF_N_EVT  = 4;
  localparam int DEF_N_ST   = 4;
  localparam int DEF_SORT_W = 3;
  localparam int DEF_MT_W   = 1 << DEF_SORT_W;
  localparam int DEF_G_W    = DEF_N_PROC * DEF_N_ST * DEF_N_ST * DEF_MT_W;

  function automatic int gidx(input int p, input int cur, input int nxt, input int m);
    return ((p * DEF_N_ST + cur) * DEF_N_ST + nxt) * DEF_MT_W + m;
  endfunction

  // Guard table for the default two-process network
  function automatic logic [DEF_G_W-1:0] default_guards();
    logic [DEF_G_W-1:0] g;
    g = '0;
    // process 0 (sort a,b,c)
    g[gidx(0, 0, 0, 0)] = 1'b1;
    g[gidx(0, 0, 1, 5)] = 1'b1;
    g[gidx(0, 0, 2, 2)] = 1'b1;
    g[gidx(0, 1, 1, 0)] = 1'b1;
    g[gidx(0, 1, 1, 2)] = 1'b1;
    g[gidx(0, 1, 2, 1)] = 1'b1;
    g[gidx(0, 2, 2, 0)] = 1'b1;
    g[gidx(0, 2, 3, 3)] = 1'b1;
    g[gidx(0, 3, 3, 0)] = 1'b1;
    g[gidx(0, 3, 3, 4)] = 1'b1;
    g[gidx(0, 3, 1, 1)] = 1'b1;
    // process 1 (sort c,d)
    g[gidx(1, 0, 0, 0)] = 1'b1;
    g[gidx(1, 0, 1, 1)] = 1'b1;
    g[gidx(1, 0, 2, 2)] = 1'b1;
    g[gidx(1, 1, 1, 0)] = 1'b1;
    g[gidx(1, 1, 0, 2)] = 1'b1;
    g[gidx(1, 1, 0, 3)] = 1'b1;
    g[gidx(1, 1, 2, 3)] = 1'b1;
    g[gidx(1, 2, 2, 0)] = 1'b1;
    g[gidx(1, 2, 0, 1)] = 1'b1;
    return g;
  endfunction

endpackage

// File: rtl/evt_minterm_dec.sv
module evt_minterm_dec #(
  parameter int N_EVT  = 4,
  parameter int SORT_W = 3,
  parameter logic [N_EVT-1:0] MASK = '1,
  localparam int MT_W  = 1 << SORT_W
) (
  input  logic [N_EVT-1:0] evt,
  output logic [MT_W-1:0]  mt
);

  logic [SORT_W-1:0] packed_idx;

  // compact the events of the sort, lowest wire first
  always_comb begin
    int k;
    packed_idx = '0;
    k = 0;
    for (int e = 0; e < N_EVT; e++) begin
      if (MASK[e] && (k < SORT_W)) begin
        packed_idx[k] = evt[e];
        k = k + 1;
      end
    end
  end

  always_comb begin
    mt = '0;
    mt[packed_idx] = 1'b1;
  end

endmodule

// File: rtl/evt_proc.sv
module evt_proc #(
  parameter int N_ST = 4,
  parameter int MT_W = 8,
  parameter logic [N_ST*N_ST*MT_W-1:0] GUARD = '0,
  parameter logic [N_ST-1:0] INIT = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [MT_W-1:0] mt,
  input  logic            sync,
  output logic            req,
  output logic [N_ST-1:0] state
);

  logic [N_ST-1:0] hit [N_ST];
  logic [N_ST-1:0] sel;
  logic [N_ST-1:0] sel_pri;

  // requesters: guard of arc (cur -> nxt) qualified by the current-state bit
  for (genvar c = 0; c < N_ST; c++) begin : g_cur
    for (genvar n = 0; n < N_ST; n++) begin : g_nxt
      assign hit[c][n] = state[c] & (|(GUARD[(c*N_ST+n)*MT_W +: MT_W] & mt));
    end
  end

  // next-state selects
  always_comb begin
    sel = '0;
    for (int c = 0; c < N_ST; c++) sel = sel | hit[c];
  end

  // lowest-numbered target wins
  always_comb begin
    sel_pri = '0;
    for (int n = N_ST - 1; n >= 0; n--) begin
      if (sel[n]) sel_pri = '0;
      if (sel[n]) sel_pri[n] = 1'b1;
    end
  end

  assign req = |sel;

  always_ff @(posedge clk) begin
    if (rst)              state <= INIT;
    else if (sync && req) state <= sel_pri;
  end

endmodule

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int N_PROC = 2
) (
  input  logic [N_PROC-1:0] req,
  output logic              sync
);

  assign sync = &req;

endmodule

// File: rtl/evt_fsm_net.sv
module evt_fsm_net #(
  parameter int N_PROC = evt_net_pkg::DEF_N_PROC,
  parameter int N_EVT  = evt_net_pkg::DEF_N_EVT,
  parameter int N_ST   = evt_net_pkg::DEF_N_ST,
  parameter int SORT_W = evt_net_pkg::DEF_SORT_W,
  parameter logic [N_PROC*N_EVT-1:0] SORT_MASK = 8'b1100_0111,
  parameter logic [N_PROC*N_ST-1:0]  INIT_ST   = 8'b0001_0001,
  parameter logic [N_PROC*N_ST*N_ST*(1<<SORT_W)-1:0] GUARDS = evt_net_pkg::default_guards(),
  localparam int MT_W = 1 << SORT_W,
  localparam int PG_W = N_ST * N_ST * MT_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_EVT-1:0]       evt_in,
  output logic [N_PROC*N_ST-1:0] state_out,
  output logic [N_PROC-1:0]      req_out,
  output logic                   sync_out
);

  logic [MT_W-1:0] mt [N_PROC];

  for (genvar p = 0; p < N_PROC; p++) begin : g_proc
    evt_minterm_dec #(
      .N_EVT (N_EVT),
      .SORT_W(SORT_W),
      .MASK  (SORT_MASK[p*N_EVT +: N_EVT])
    ) u_dec (
      .evt(evt_in),
      .mt (mt[p])
    );

    evt_proc #(
      .N_ST (N_ST),
      .MT_W (MT_W),
      .GUARD(GUARDS[p*PG_W +: PG_W]),
      .INIT (INIT_ST[p*N_ST +: N_ST])
    ) u_proc (
      .clk  (clk),
      .rst  (rst),
      .mt   (mt[p]),
      .sync (sync_out),
      .req  (req_out[p]),
      .state(state_out[p*N_ST +: N_ST])
    );
  end

  evt_sync #(.N_PROC(N_PROC)) u_sync (
    .req (req_out),
    .sync(sync_out)
  );

endmodule

// File: rtl/evt_net_chk.sv
module evt_net_chk #(
  parameter int N_PROC = 2,
  parameter int N_ST   = 4,
  parameter logic [N_PROC*N_ST-1:0] INIT_ST = '0
) (
  input logic                   clk,
  input logic                   rst,
  input logic [N_PROC*N_ST-1:0] state_out,
  input logic [N_PROC-1:0]      req_out,
  input logic                   sync_out
);

  logic rst_q = 1'b0;

  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q) begin
      AST_RESET_INIT: assert (state_out == INIT_ST); // R1
    end
  end

  for (genvar p = 0; p < N_PROC; p++) begin : g_oh
    AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
      $countones(state_out[p*N_ST +: N_ST]) == 1); // R2
  end

  AST_SYNC_ALL_REQ: assert property (@(posedge clk) disable iff (rst)
    sync_out == (&req_out)); // R5

  AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !sync_out |=> $stable(state_out)); // R6

endmodule

bind evt_fsm_net evt_net_chk #(
  .N_PROC (N_PROC),
  .N_ST   (N_ST),
  .INIT_ST(INIT_ST)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .state_out(state_out),
  .req_out  (req_out),
  .sync_out (sync_out)
);

// File: tb/sim_evt_fsm_net.sv
module sim_evt_fsm_net;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] evt_in = '0;
  logic [7:0] state_out;
  logic [1:0] req_out;
  logic       sync_out;

  int n_chk = 0;
  int n_fail = 0;
  int p_st = 0;
  int q_st = 0;

  always #2.5 clk = ~clk;

  evt_fsm_net u0 (
    .clk(clk), .rst(rst), .evt_in(evt_in),
    .state_out(state_out), .req_out(req_out), .sync_out(sync_out)
  );

  // {evt[3:0], P state[1:0], Q state[1:0], sync}; states after the edge
  localparam logic [8:0] VEC [15] = '{
    {4'b0000, 2'd0, 2'd0, 1'b1},  // R4 null event: all stay
    {4'b0101, 2'd1, 2'd1, 1'b1},  // R4 P S1 m5->S2, Q m1->U1 (shared c)
    {4'b0001, 2'd2, 2'd1, 1'b1},  // R3 a only: Q sees null
    {4'b0100, 2'd2, 2'd1, 1'b0},  // R6 both refuse
    {4'b1000, 2'd2, 2'd0, 1'b1},  // R4 Q U1 m2->U0
    {4'b0011, 2'd3, 2'd0, 1'b1},  // R4 P S3 m3->S4
    {4'b0100, 2'd3, 2'd1, 1'b1},  // R4 P S4 m4 stays, Q m1->U1
    {4'b1100, 2'd3, 2'd0, 1'b1},  // R7 Q U1 m3 -> U0 (lowest)
    {4'b1000, 2'd3, 2'd2, 1'b1},  // R4 Q U0 m2->U2
    {4'b0010, 2'd3, 2'd2, 1'b0},  // R6 P refuses
    {4'b0101, 2'd3, 2'd2, 1'b0},  // R6 Q would move, P refuses
    {4'b0001, 2'd1, 2'd2, 1'b1},  // R4 P S4 m1->S2
    {4'b0100, 2'd1, 2'd2, 1'b0},  // R6 P refuses, Q would move
    {4'b0010, 2'd1, 2'd2, 1'b1},  // R3 b only: P m2 stays, Q null
    {4'b1000, 2'd1, 2'd2, 1'b0}   // R5 Q U2 refuses m2
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void p_model(input int s, input int m, output bit ok, output int nx);
    ok = 1'b1; nx = s;
    case (s)
      0: if (m == 5) nx = 1; else if (m == 2) nx = 2; else if (m != 0) ok = 1'b0;
      1: if (m == 1) nx = 2; else if (m != 0 && m != 2) ok = 1'b0;
      2: if (m == 3) nx = 3; else if (m != 0) ok = 1'b0;
      default: if (m == 1) nx = 1; else if (m != 0 && m != 4) ok = 1'b0;
    endcase
  endfunction

  function automatic void q_model(input int s, input int m, output bit ok, output int nx);
    ok = 1'b1; nx = s;
    case (s)
      0: if (m == 1) nx = 1; else if (m == 2) nx = 2; else if (m != 0) ok = 1'b0;
      1: if (m == 2 || m == 3) nx = 0; else if (m != 0) ok = 1'b0;
      default: if (m == 1) nx = 0; else if (m != 0) ok = 1'b0;
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit pok, qok;
    int pn, qn;
    logic [7:0] expv;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", 32'(state_out), 32'h11);
    rst = 1'b0;

    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      evt_in = VEC[i][8:5];
      #1;
      check($sformatf("R5 R8 sync vec %0d", i), 32'(sync_out), 32'(VEC[i][0]));
      @(posedge clk);
      #1;
      expv = 8'((1 << VEC[i][2:1]) << 4) | 8'(1 << VEC[i][4:3]);
      check($sformatf("R4 state vec %0d", i), 32'(state_out), 32'(expv));
    end

    // random walk against the reference model
    p_st = 1; q_st = 2;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      evt_in = 4'($urandom_range(0, 15));
      p_model(p_st, int'({evt_in[2], evt_in[1], evt_in[0]}), pok, pn);
      q_model(q_st, int'({evt_in[3], evt_in[2]}), qok, qn);
      #1;
      check("R5 random req", 32'(req_out), 32'({qok, pok}));
      check("R6 random sync", 32'(sync_out), 32'(pok & qok));
      if (pok && qok) begin p_st = pn; q_st = qn; end
      @(posedge clk);
      #1;
      check("R2 one-hot P", 32'($countones(state_out[3:0])), 32'd1);
      check("R2 one-hot Q", 32'($countones(state_out[7:4])), 32'd1);
      check("R4 random state", 32'(state_out),
            32'(((1 << q_st) << 4) | (1 << p_st)));
    end

    // reset in the middle of a run, with an event that would move P
    @(negedge clk);
    evt_in = 4'b0001;
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 mid-run reset", 32'(state_out), 32'h11);
    @(negedge clk);
    rst = 1'b0;
    evt_in = 4'b0010;
    #1;
    check("R5 after reset sync", 32'(sync_out), 32'd1);
    @(posedge clk);
    #1;
    check("R4 S1 m2 to S3", 32'(state_out), 32'h14);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule